// File: doc/BRIEF.md
# Write-only two-wire configuration receiver

This block is a receive-only slave for a two-wire serial bus with one clock line and one data line. It programs the control registers of a clock generator. Both bus lines are oversampled by the system clock. The block recognises START and STOP conditions and checks the first byte of each transaction against a fixed 7-bit device address with a write direction bit. It then follows a fixed ten-byte block-write layout:

- an address byte;
- a command byte, whose value is ignored;
- a count byte, whose value is ignored;
- seven data bytes. Only the last four data bytes carry configuration.

The four configuration bytes are first collected in staging registers. They are copied into the live registers together, and only when a STOP closes a frame that delivered every byte. A frame that ends early, is cut by a repeated START, or is addressed elsewhere leaves the live registers untouched. The live registers leave reset with defined defaults, so the clock generator runs without any bus traffic. Bits marked reserved are always held at zero. The block never drives register contents onto the bus. The only thing it places on the data line is the acknowledge pulse. The live register contents feed the output-enable and frequency-select logic around it.

Top module: `cfgwr_rx`

## Requirements
- R1: After reset, `cfg_o` equals the default value with reserved bits cleared, and `sda_drive_low_o` is 0.
- R2: An address byte equal to the device address followed by a 0 direction bit (0xD2 with the default address, sent MSB first) is acknowledged: `sda_drive_low_o` is 1 while SCL is high on the ninth clock.
- R3: Any other address byte, including 0xD3 (the read direction), is not acknowledged. No later byte of that transaction is acknowledged either, and `cfg_o` does not change.
- R4: After a STOP that closes a matched frame of ten bytes, register r of `cfg_o` (bits 8r+7..8r) holds the frame's byte at position 6+r, where position 0 is the address, for r = 0..3.
- R5: The values of the command byte, the count byte and data bytes 0..2 (positions 1..5) have no effect on `cfg_o`.
- R6: In a matched frame, every byte after the address is acknowledged as well. The acknowledge starts while SCL is low.
- R7: Bits set in the reserved mask read as 0 in `cfg_o`, even when a frame writes 1 to them.
- R8: A STOP after fewer than ten bytes of a matched frame leaves `cfg_o` unchanged.
- R9: A repeated START discards the frame in progress, even if all ten bytes were already received. Only a later complete frame that is closed by a STOP commits.
- R10: Bytes after position 9 are acknowledged and ignored, and the byte counter saturates, so the committed values remain those at positions 6..9.
- R11: `cfg_o` changes only at a STOP. After the tenth byte and before the STOP it still shows the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_drive_low_o | output | 1 | 1 pulls the data line low for an acknowledge |
| cfg_o | output | NUM_REGS*8 | Live configuration registers, register r in bits 8r+7..8r |

## Verification
The bench builds the block with its default address (0x69, giving 0xD2 on the wire), ten-byte frames and four registers. It sets the defaults to 0x31C27E40 and the reserved mask to 0x80010108, so that one reserved bit falls in every register and the reset value is distinguishable from zero. With these values all 256 possible first bytes can be swept one transaction at a time, each with its expected acknowledge. All eight single-bit corruptions of the address are then run as full frames. Generated data patterns exercise commits, forced reserved bits, short frames, repeated starts and overlong frames. Every expected register value is computed from the byte positions and the mask.

// File: rtl/cfgwr_pkg.sv
package cfgwr_pkg;

    // Receive phase of the frame engine
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_ACK,
        PH_SKIP
    } rx_phase_e;

    // Bus events decoded from the synchronised lines
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

endpackage

// File: rtl/cfgwr_linesync.sv
module cfgwr_linesync #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output cfgwr_pkg::bus_ev_t  ev_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_st_t;

    sync_st_t q, d;
    logic scl_s, sda_s;

    assign scl_s = q.scl_pipe[STAGES-1];
    assign sda_s = q.sda_pipe[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_pipe: '1, sda_pipe: '1, scl_prev: 1'b1, sda_prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ev_o.scl   = scl_s;
        ev_o.sda   = sda_s;
        ev_o.rise  = scl_s & ~q.scl_prev;
        ev_o.fall  = ~scl_s & q.scl_prev;
        ev_o.start = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
        ev_o.stop  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
    end

endmodule

// File: rtl/cfgwr_frame.sv
module cfgwr_frame #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         FRAME_BYTES = 10,
    parameter int         IDX_W       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cfgwr_pkg::bus_ev_t  ev_i,
    output logic                sda_oe_o,
    output logic                stb_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic [7:0]          byte_o,
    output logic                start_o,
    output logic                stop_o
);
    import cfgwr_pkg::*;

    localparam logic [7:0]       ADDR_BYTE = {DEV_ADDR, 1'b0};
    localparam logic [IDX_W-1:0] IDX_SAT   = IDX_W'(FRAME_BYTES);

    typedef struct packed {
        rx_phase_e        phase;
        logic [7:0]       sh;
        logic [3:0]       bits;
        logic [IDX_W-1:0] idx;
        logic             match;
        logic             oe;
        logic             stb;
        logic [IDX_W-1:0] sidx;
        logic [7:0]       sbyte;
        logic             start;
        logic             stop;
    } frame_st_t;

    frame_st_t q, d;

    always_comb begin
        d       = q;
        d.stb   = 1'b0;
        d.start = 1'b0;
        d.stop  = 1'b0;
        if (ev_i.start) begin
            d.phase = PH_SHIFT;
            d.bits  = '0;
            d.idx   = '0;
            d.match = 1'b0;
            d.oe    = 1'b0;
            d.start = 1'b1;
        end else if (ev_i.stop) begin
            d.phase = PH_IDLE;
            d.oe    = 1'b0;
            d.stop  = q.match;
        end else begin
            unique case (q.phase)
                PH_SHIFT: begin
                    if (ev_i.rise && q.bits < 4'd8) begin
                        d.sh   = {q.sh[6:0], ev_i.sda};
                        d.bits = q.bits + 4'd1;
                    end else if (ev_i.fall && q.bits == 4'd8) begin
                        d.bits = '0;
                        if (q.idx == '0) begin
                            if (q.sh == ADDR_BYTE) begin
                                d.match = 1'b1;
                                d.oe    = 1'b1;
                                d.phase = PH_ACK;
                            end else begin
                                d.phase = PH_SKIP;
                            end
                        end else begin
                            d.oe    = 1'b1;
                            d.phase = PH_ACK;
                            d.stb   = 1'b1;
                            d.sidx  = q.idx;
                            d.sbyte = q.sh;
                        end
                        if (q.idx != IDX_SAT) begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
                PH_ACK: begin
                    if (ev_i.fall) begin
                        d.oe    = 1'b0;
                        d.phase = PH_SHIFT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign stb_o    = q.stb;
    assign idx_o    = q.sidx;
    assign byte_o   = q.sbyte;
    assign start_o  = q.start;
    assign stop_o   = q.stop;

    AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> q.match); // R3
    AST_STB_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |-> q.match); // R3
    AST_ACK_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !ev_i.scl); // R6
    AST_IDX_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        q.idx <= IDX_SAT); // R10

endmodule

// File: rtl/cfgwr_bank.sv
module cfgwr_bank #(
    parameter int                       NUM_REGS    = 4,
    parameter int                       FIRST_IDX   = 6,
    parameter int                       LAST_IDX    = 9,
    parameter int                       IDX_W       = 4,
    parameter logic [NUM_REGS*8-1:0]    REG_DEFAULT = '0,
    parameter logic [NUM_REGS*8-1:0]    RSVD_MASK   = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [7:0]              byte_i,
    input  logic                    start_i,
    input  logic                    stop_i,
    output logic [NUM_REGS*8-1:0]   cfg_o
);
    localparam int W = NUM_REGS * 8;

    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] live;
        logic         full;
    } bank_st_t;

    bank_st_t q, d;
    logic [NUM_REGS-1:0] hit;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
        assign hit[r] = stb_i && (idx_i == IDX_W'(FIRST_IDX + r));
    end

    always_comb begin
        d = q;
        if (start_i) begin
            d.full = 1'b0;
        end
        for (int r = 0; r < NUM_REGS; r++) begin
            if (hit[r]) begin
                d.shadow[r*8 +: 8] = byte_i;
            end
        end
        if (stb_i && idx_i == IDX_W'(LAST_IDX)) begin
            d.full = 1'b1;
        end
        if (stop_i && q.full) begin
            d.live = q.shadow & ~RSVD_MASK;
            d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{shadow: '0, live: REG_DEFAULT & ~RSVD_MASK, full: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign cfg_o = q.live;

    AST_LIVE_CHANGES_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.live) |-> $past(stop_i && q.full)); // R11
    AST_SHORT_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !q.full) |=> $stable(q.live)); // R8

endmodule

// File: rtl/cfgwr_rx.sv
module cfgwr_rx #(
    parameter int                       SYNC_STAGES = 2,
    parameter logic [6:0]               DEV_ADDR    = 7'h69,
    parameter int                       FRAME_BYTES = 10,
    parameter int                       NUM_REGS    = 4,
    parameter logic [NUM_REGS*8-1:0]    REG_DEFAULT = 32'h0F_0F_03_01,
    parameter logic [NUM_REGS*8-1:0]    RSVD_MASK   = 32'h80_00_00_08
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_drive_low_o,
    output logic [NUM_REGS*8-1:0]   cfg_o
);
    localparam int IDX_W     = $clog2(FRAME_BYTES + 1);
    localparam int LAST_IDX  = FRAME_BYTES - 1;
    localparam int FIRST_IDX = FRAME_BYTES - NUM_REGS;

    cfgwr_pkg::bus_ev_t ev;
    logic               stb, start_p, stop_p;
    logic [IDX_W-1:0]   idx;
    logic [7:0]         rx_byte;

    cfgwr_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    cfgwr_frame #(
        .DEV_ADDR    (DEV_ADDR),
        .FRAME_BYTES (FRAME_BYTES),
        .IDX_W       (IDX_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_i     (ev),
        .sda_oe_o (sda_drive_low_o),
        .stb_o    (stb),
        .idx_o    (idx),
        .byte_o   (rx_byte),
        .start_o  (start_p),
        .stop_o   (stop_p)
    );

    cfgwr_bank #(
        .NUM_REGS    (NUM_REGS),
        .FIRST_IDX   (FIRST_IDX),
        .LAST_IDX    (LAST_IDX),
        .IDX_W       (IDX_W),
        .REG_DEFAULT (REG_DEFAULT),
        .RSVD_MASK   (RSVD_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_i   (stb),
        .idx_i   (idx),
        .byte_i  (rx_byte),
        .start_i (start_p),
        .stop_i  (stop_p),
        .cfg_o   (cfg_o)
    );

endmodule

// File: tb/cfgwr_rx_bench.sv
module cfgwr_rx_bench;
    localparam int          QTR  = 4;
    localparam logic [31:0] DEF  = 32'h31_C2_7E_40;
    localparam logic [31:0] RSVD = 32'h80_01_01_08;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_low;
    logic sda_bus;
    logic [31:0] cfg;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] fb [0:15];
    logic [31:0] exp_cfg;

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_low;

    cfgwr_rx #(
        .DEV_ADDR    (7'h69),
        .FRAME_BYTES (10),
        .NUM_REGS    (4),
        .REG_DEFAULT (DEF),
        .RSVD_MASK   (RSVD)
    ) u_cfgwr_rx (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (m_scl),
        .sda_i           (sda_bus),
        .sda_drive_low_o (sda_low),
        .cfg_o           (cfg)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic qw(input int n = 1);
        repeat (n * QTR) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw(); m_scl = 1'b1; qw(2); m_scl = 1'b0; qw();
        end
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
        ack = (sda_bus == 1'b0);
        qw(); m_scl = 1'b0; qw();
    endtask

    task automatic fill(input int seed);
        fb[0] = 8'hD2;
        for (int i = 1; i < 16; i++) fb[i] = 8'((seed * 37 + i * 53 + 11) & 255);
    endtask

    function automatic logic [31:0] committed();
        logic [31:0] v;
        for (int r = 0; r < 4; r++) v[r*8 +: 8] = fb[6 + r];
        return v & ~RSVD;
    endfunction

    // Sends START and nb bytes from fb; checks every acknowledge.
    task automatic send_frame(input int nb, input bit exp_ack, input string req);
        logic a;
        bus_start();
        for (int i = 0; i < nb; i++) begin
            send_byte(fb[i], a);
            chk(a == exp_ack, req, {31'd0, a}, {31'd0, exp_ack});
        end
    endtask

    initial begin
        logic a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_cfg = DEF & ~RSVD;
        chk(cfg == exp_cfg, "R1 reset value", cfg, exp_cfg);
        chk(sda_low == 1'b0, "R1 data line released", {31'd0, sda_low}, 32'd0);

        // R2/R3: sweep every possible first byte
        for (int b = 0; b < 256; b++) begin
            bus_start();
            send_byte(8'(b), a);
            chk(a == (b == 8'hD2), (b == 8'hD2) ? "R2 address ack" : "R3 address nack",
                {31'd0, a}, {31'd0, b == 8'hD2});
            bus_stop();
        end
        chk(cfg == exp_cfg, "R3 sweep leaves cfg", cfg, exp_cfg);

        // R4/R6/R11: full frames with varying patterns
        for (int k = 0; k < 6; k++) begin
            fill(k);
            send_frame(10, 1'b1, "R6 byte ack");
            chk(cfg == exp_cfg, "R11 no change before STOP", cfg, exp_cfg);
            bus_stop();
            exp_cfg = committed();
            chk(cfg == exp_cfg, "R4 commit", cfg, exp_cfg);
        end

        // R7: all ones into committed bytes
        fill(9);
        for (int i = 6; i < 10; i++) fb[i] = 8'hFF;
        send_frame(10, 1'b1, "R6 byte ack");
        bus_stop();
        exp_cfg = ~RSVD;
        chk(cfg == exp_cfg, "R7 reserved bits zero", cfg, exp_cfg);
        chk((cfg & RSVD) == 32'd0, "R7 reserved mask", cfg & RSVD, 32'd0);

        // R5: ignored positions full of ones, committed ones distinct
        for (int k = 0; k < 2; k++) begin
            fill(20 + k);
            for (int i = 1; i < 6; i++) fb[i] = (k == 0) ? 8'hFF : 8'h00;
            for (int i = 6; i < 10; i++) fb[i] = (k == 0) ? 8'h00 : 8'h12 + 8'(i);
            send_frame(10, 1'b1, "R6 byte ack");
            bus_stop();
            exp_cfg = committed();
            chk(cfg == exp_cfg, "R5 ignored bytes", cfg, exp_cfg);
        end

        // R3: full frames with corrupted address
        for (int bit_i = 0; bit_i < 8; bit_i++) begin
            fill(30 + bit_i);
            fb[0] = 8'hD2 ^ (8'h01 << bit_i);
            send_frame(10, 1'b0, "R3 no ack after bad address");
            bus_stop();
            chk(cfg == exp_cfg, "R3 bad address no commit", cfg, exp_cfg);
        end

        // R8: short frames
        for (int nb = 7; nb <= 9; nb++) begin
            fill(40 + nb);
            send_frame(nb, 1'b1, "R6 byte ack");
            bus_stop();
            chk(cfg == exp_cfg, "R8 short frame", cfg, exp_cfg);
        end

        // R9: repeated START after 6 bytes, then complete frame
        fill(50);
        send_frame(6, 1'b1, "R6 byte ack");
        fill(51);
        send_frame(10, 1'b1, "R6 byte ack");
        chk(cfg == exp_cfg, "R9 no commit before STOP", cfg, exp_cfg);
        bus_stop();
        exp_cfg = committed();
        chk(cfg == exp_cfg, "R9 frame after restart", cfg, exp_cfg);

        // R9: full frame cut by repeated START, then address-only STOP
        fill(52);
        send_frame(10, 1'b1, "R6 byte ack");
        send_frame(1, 1'b1, "R2 address ack");
        bus_stop();
        chk(cfg == exp_cfg, "R9 restart discards full frame", cfg, exp_cfg);

        // R10: overlong frame
        fill(60);
        send_frame(14, 1'b1, "R10 extra byte ack");
        bus_stop();
        exp_cfg = committed();
        chk(cfg == exp_cfg, "R10 overlong frame commit", cfg, exp_cfg);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule